// File: doc/BRIEF.md
# Interleaved Cache-Line Refill Controller

This block fills one cache line of four words from a main memory made of four banks that hold consecutive word addresses in turn. A requester presents a word address and a memory organisation mode. The controller drives the line address once onto the address path that all banks share. It then waits out the bank access time and returns the words one by one over a single-word data bus. Each returned word carries a valid strobe and its index within the line. A one-cycle done pulse closes the refill, and the controller reports how many cycles the refill took.

Three organisations can be selected so their cost can be compared on the same storage. In simple mode each word pays the full address, access and transfer time. In wide mode the whole line arrives at once, and a multiplexer hands out only the addressed word. In interleaved mode the four banks access in parallel and their words leave on consecutive cycles. The bank contents are a fixed pattern loaded at reset. Only one refill is in flight at a time, because the banks share the address path.

Top module: `ilv_fetch_ctrl`

## Requirements
- R1: While reset is held and right after it, `busy`, `word_valid` and `done` are low and `last_cycles` is 0.
- R2: A request is taken only on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle up to and including the `done` cycle, and low on the cycle after `done`.
- R3: With `req_mode` 2 or 3 (interleaved), count the first cycle after the accepting edge as cycle 1. Words then appear on cycles 8, 9, 10 and 11, and the refill takes 1 + 6 + 4 = 11 cycles.
- R4: With `req_mode` 0 (simple), words appear on cycles 8, 16, 24 and 32, and the refill takes 4 x (1 + 6 + 1) = 32 cycles.
- R5: With `req_mode` 1 (wide), exactly one word appears, on cycle 8. Its `word_idx` equals `req_addr[1:0]` and its data is that of `req_addr`. The refill takes 8 cycles.
- R6: In simple and interleaved modes the words come out with `word_idx` 0, 1, 2, 3 in that order. They are the words of the aligned line `req_addr[7:2]`, whatever `req_addr[1:0]` holds.
- R7: The word at word address a holds a XOR 0xA5A50000. The word is stored in bank a mod 4 at row a / 4.
- R8: `done` is a single-cycle pulse on the cycle after the last word. `last_cycles` takes the refill's cycle count in that cycle and holds it until the next `done`.
- R9: A request raised while `busy` is high has no effect. The refill in progress returns its own data and timing, and no further words or `done` follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | 8 | Word address of the request |
| req_mode | input | 2 | 0 simple, 1 wide, 2 or 3 interleaved |
| busy | output | 1 | Refill in progress; new requests are not taken |
| word_valid | output | 1 | A returned word is on `word_data` |
| word_idx | output | 2 | Index of the returned word within the line |
| word_data | output | 32 | Returned word |
| done | output | 1 | One-cycle end-of-refill pulse |
| last_cycles | output | 6 | Cycle count of the most recent refill |

## Verification
Every line address is refilled in interleaved and simple modes, and every word address in wide mode. This shows whether the bank and row decode and the word ordering hold across all banks and rows. It also shows whether each mode keeps its own spacing between words: consecutive cycles, every eighth cycle, or a single word. Requests with nonzero low address bits in the line-based modes separate alignment from the wide-mode word select. A second request raised partway through a refill checks that the shared address path is never taken over.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        MODE_SIMPLE = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_ILV    = 2'd2
    } org_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACC,
        ST_XFER,
        ST_FIN
    } fetch_st_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int          DATA_W  = 32,
    parameter int          ROW_W   = 6,
    parameter int          IDX_W   = 2,
    parameter int          BANK_ID = 0,
    parameter logic [31:0] SEED    = 32'hA5A5_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  row,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS   = 1 << ROW_W;
    localparam int ADDR_W = ROW_W + IDX_W;

    logic [DATA_W-1:0] cells_q [ROWS];

    // Read-only pattern store, loaded while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells_q[r] <= DATA_W'({ROW_W'(r), IDX_W'(BANK_ID)}) ^ DATA_W'(SEED);
            end
        end
    end

    assign rdata = cells_q[row];

    logic unused_w;
    assign unused_w = ^ADDR_W;
endmodule

// File: rtl/ilv_fetch_fsm.sv
module ilv_fetch_fsm
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NB     = 4,
    parameter int T_ADDR = 1,
    parameter int T_ACC  = 6,
    parameter int T_XFER = 1,
    parameter int CNT_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_mode,
    output logic                      busy,
    output logic                      word_valid,
    output logic [$clog2(NB)-1:0]     word_idx,
    output logic [ADDR_W-$clog2(NB)-1:0] line_row,
    output logic                      done,
    output logic [CNT_W-1:0]          last_cycles
);
    localparam int IDX_W  = $clog2(NB);
    localparam int ROW_W  = ADDR_W - IDX_W;
    localparam int PH_MAX = (T_ACC > T_ADDR) ? ((T_ACC > T_XFER) ? T_ACC : T_XFER)
                                            : ((T_ADDR > T_XFER) ? T_ADDR : T_XFER);
    localparam int PH_W   = $clog2(PH_MAX + 1);

    typedef struct packed {
        fetch_st_e        st;
        org_mode_e        mode;
        logic [PH_W-1:0]  ph;
        logic [IDX_W-1:0] idx;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st  = ST_ADDR;
                    ctl_d.ph  = '0;
                    ctl_d.cnt = '0;
                    ctl_d.row = req_addr[ADDR_W-1:IDX_W];
                    unique case (req_mode)
                        2'd0:    ctl_d.mode = MODE_SIMPLE;
                        2'd1:    ctl_d.mode = MODE_WIDE;
                        default: ctl_d.mode = MODE_ILV;
                    endcase
                    ctl_d.idx = (req_mode == 2'd1) ? req_addr[IDX_W-1:0] : '0;
                end
            end
            ST_ADDR: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.ph == PH_W'(T_ADDR - 1)) begin
                    ctl_d.st = ST_ACC;
                    ctl_d.ph = '0;
                end else begin
                    ctl_d.ph = ctl_q.ph + PH_W'(1);
                end
            end
            ST_ACC: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.ph == PH_W'(T_ACC - 1)) begin
                    ctl_d.st = ST_XFER;
                    ctl_d.ph = '0;
                end else begin
                    ctl_d.ph = ctl_q.ph + PH_W'(1);
                end
            end
            ST_XFER: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.ph == PH_W'(T_XFER - 1)) begin
                    ctl_d.ph = '0;
                    if (ctl_q.mode == MODE_WIDE || ctl_q.idx == IDX_W'(NB - 1)) begin
                        ctl_d.st   = ST_FIN;
                        ctl_d.last = ctl_q.cnt + CNT_W'(1);
                    end else begin
                        ctl_d.idx = ctl_q.idx + IDX_W'(1);
                        ctl_d.st  = (ctl_q.mode == MODE_SIMPLE) ? ST_ADDR : ST_XFER;
                    end
                end else begin
                    ctl_d.ph = ctl_q.ph + PH_W'(1);
                end
            end
            ST_FIN:  ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.mode <= MODE_SIMPLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign word_valid  = (ctl_q.st == ST_XFER) && (ctl_q.ph == PH_W'(T_XFER - 1));
    assign word_idx    = ctl_q.idx;
    assign line_row    = ctl_q.row;
    assign done        = (ctl_q.st == ST_FIN);
    assign last_cycles = ctl_q.last;
endmodule

// File: rtl/ilv_fetch_ctrl.sv
module ilv_fetch_ctrl
    import ilv_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter int          NB     = 4,
    parameter int          T_ADDR = 1,
    parameter int          T_ACC  = 6,
    parameter int          T_XFER = 1,
    parameter logic [31:0] SEED   = 32'hA5A5_0000,
    parameter int          CNT_W  = $clog2(NB * (T_ADDR + T_ACC + T_XFER) + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_mode,
    output logic                  busy,
    output logic                  word_valid,
    output logic [$clog2(NB)-1:0] word_idx,
    output logic [DATA_W-1:0]     word_data,
    output logic                  done,
    output logic [CNT_W-1:0]      last_cycles
);
    localparam int IDX_W = $clog2(NB);
    localparam int ROW_W = ADDR_W - IDX_W;

    logic [ROW_W-1:0]  shared_row;
    logic [DATA_W-1:0] bank_rd [NB];

    ilv_fetch_fsm #(
        .ADDR_W(ADDR_W), .NB(NB), .T_ADDR(T_ADDR), .T_ACC(T_ACC),
        .T_XFER(T_XFER), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mode(req_mode), .busy(busy), .word_valid(word_valid),
        .word_idx(word_idx), .line_row(shared_row), .done(done),
        .last_cycles(last_cycles)
    );

    // One bank per word position, all on the shared row address.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        ilv_bank #(
            .DATA_W(DATA_W), .ROW_W(ROW_W), .IDX_W(IDX_W),
            .BANK_ID(b), .SEED(SEED)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .row(shared_row), .rdata(bank_rd[b])
        );
    end

    // Word select: the index picks the bank whose word leaves this cycle.
    assign word_data = bank_rd[word_idx];
endmodule

// File: rtl/ilv_fetch_chk.sv
module ilv_fetch_chk #(
    parameter int NB     = 4,
    parameter int T_ADDR = 1,
    parameter int T_ACC  = 6,
    parameter int T_XFER = 1,
    parameter int CNT_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             word_valid,
    input logic             done,
    input logic [CNT_W-1:0] last_cycles
);
    localparam int L_SIMPLE = NB * (T_ADDR + T_ACC + T_XFER);
    localparam int L_WIDE   = T_ADDR + T_ACC + T_XFER;
    localparam int L_ILV    = T_ADDR + T_ACC + NB * T_XFER;

    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_valid)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(last_cycles)); // R8
    AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_cycles == CNT_W'(L_SIMPLE) || last_cycles == CNT_W'(L_WIDE)
                  || last_cycles == CNT_W'(L_ILV))); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!word_valid && !done)); // R9
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
endmodule

bind ilv_fetch_ctrl ilv_fetch_chk #(
    .NB(NB), .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .word_valid(word_valid),
    .done(done), .last_cycles(last_cycles)
);

// File: tb/ilv_fetch_ctrl_test.sv
`timescale 1ns/1ps
module ilv_fetch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic        busy, word_valid, done;
    logic [1:0]  word_idx;
    logic [31:0] word_data;
    logic [5:0]  last_cycles;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ilv_fetch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mode(req_mode), .busy(busy), .word_valid(word_valid),
        .word_idx(word_idx), .word_data(word_data), .done(done),
        .last_cycles(last_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'(a) ^ 32'hA5A5_0000; // R7 stored pattern
    endfunction

    // One refill; optionally raise an intruding request on cycle 3 (R9).
    task automatic refill(input int mode, input int addr, input bit intrude);
        int nw, got, exp_cyc, exp_idx, exp_total, done_cyc;
        string rq;
        rq = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R3";
        nw = (mode == 1) ? 1 : 4;
        exp_total = (mode == 0) ? 32 : (mode == 1) ? 8 : 11;
        got = 0;
        done_cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'(addr); req_mode = 2'(mode);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
        for (int c = 1; c <= 40; c++) begin
            if (intrude && c == 3) begin
                req_valid = 1'b1; req_addr = 8'(addr ^ 8'h55); req_mode = 2'd0;
            end
            if (intrude && c == 4) req_valid = 1'b0;
            if (word_valid) begin
                exp_cyc = (mode == 0) ? 8 * (got + 1) : 8 + got;
                exp_idx = (mode == 1) ? (addr & 3) : got;
                chk(c == exp_cyc, rq, "word cycle", c, exp_cyc);
                chk(int'(word_idx) == exp_idx, "R6", "word index", word_idx, exp_idx);
                chk(word_data == pat((addr & ~3) | exp_idx), "R7", "word data",
                    word_data, pat((addr & ~3) | exp_idx));
                got++;
            end
            if (done) begin
                done_cyc = c;
                break;
            end
            @(negedge clk);
        end
        chk(got == nw, rq, "word count", got, nw);
        chk(done_cyc == exp_total + 1, "R8", "done cycle", done_cyc, exp_total + 1);
        chk(int'(last_cycles) == exp_total, rq, "cycle count", last_cycles, exp_total);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R2", "idle after done", {busy, done}, 0);
        if (intrude) begin
            for (int k = 0; k < 40; k++) begin
                chk(!word_valid && !done, "R9", "no activity after ignored request",
                    {word_valid, done}, 0);
                @(negedge clk);
            end
            chk(int'(last_cycles) == exp_total, "R8", "count held", last_cycles, exp_total);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, word_valid, done} == 3'b0, "R1", "outputs in reset", {busy, word_valid, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, word_valid, done} == 3'b0, "R1", "outputs after reset", {busy, word_valid, done}, 0);
        chk(last_cycles == 6'd0, "R1", "count after reset", last_cycles, 0);
        // Interleaved, every line, mixed low bits (R3, R6)
        for (int l = 0; l < 64; l++) refill((l % 2) ? 3 : 2, l * 4 + (l % 4), 1'b0);
        // Simple, every line (R4)
        for (int l = 0; l < 64; l++) refill(0, l * 4 + ((l * 3) % 4), 1'b0);
        // Wide, every word address (R5)
        for (int a = 0; a < 256; a++) refill(1, a, 1'b0);
        // Intruding requests in each mode (R9)
        refill(2, 8'h37, 1'b1);
        refill(0, 8'hC2, 1'b1);
        refill(1, 8'h5B, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule